// File: doc/BRIEF.md
# Vector Element Loop Sequencer

This block walks the index space of one vector operation: a number of elements (the vector length) each made of one to four sub-elements. For every issued pair it reports a source element index, a source sub-element index, a destination element index and a destination sub-element index. Two counters advance in lock step, one for the source side and one for the destination side. Each side has its own order bit. With the bit clear, the element index is the outer loop and the sub-element index runs inside it. With the bit set, the sub-element index becomes the outer loop.

A start pulse latches the configuration. In horizontal mode the block then issues every pair on consecutive cycles. In vertical-first mode it waits for a step strobe, then issues the pairs of one parallelism group and stops. Source elements belong to the same group when their source element index divided by the hint (rounded down) is equal. The last element of the vector always closes a group. A hint of zero disables grouping, so each strobe issues exactly one pair.

The controller has four named states. IDLE holds until a start with a nonzero length. It moves to HRUN in horizontal mode and to VWAIT in vertical-first mode. HRUN issues every cycle and returns to IDLE after the final pair. VWAIT moves to VRUN on a step strobe. VRUN issues every cycle. It returns to VWAIT after a pair that closes a group, or to IDLE after the final pair.

Top module: `vec_step_seq`

## Requirements
- R1: After reset, `issue_valid`, `done` and `group_end` are low and all four index outputs are zero.
- R2: A `start` pulse in IDLE with nonzero `vl` latches `vl`, `subvl_m1` (sub-element count minus one), `pack`, `unpack`, `hint` and `vf_mode`. The first pair (all indices zero) is presented one cycle later in horizontal mode.
- R3: With `pack` low the source element index is the outer loop and the source sub-element index the inner loop. With `unpack` low the destination side runs the same way.
- R4: With `pack` high the source sub-element index is the outer loop and the source element index runs 0..vl-1 inside it.
- R5: `unpack` high inverts only the destination nesting. The source side follows `pack` alone.
- R6: In horizontal mode all vl×(subvl_m1+1) pairs are issued on consecutive cycles, and `step` has no effect.
- R7: `done` is high exactly on the cycle the final pair is issued. The next cycle `issue_valid` is low and all indices are zero.
- R8: In vertical-first mode no pair is issued until `step` is seen in VWAIT. Pairs are then issued on consecutive cycles, and issue stops on the cycle after a pair with `group_end` high.
- R9: With a nonzero hint, `group_end` is high on an issued pair when it is the final pair, or when the next pair's floor(source element index / hint) differs from the current one. This includes a short last group when vl is not a multiple of the hint.
- R10: With a hint of zero, `group_end` is high on every issued pair, and each step strobe in vertical-first mode issues exactly one pair.
- R11: A `start` with `vl` equal to zero is ignored: no pair is issued and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken in IDLE only) |
| vl | input | VL_W | Number of elements |
| subvl_m1 | input | SUB_W | Sub-elements per element, minus one |
| pack | input | 1 | Invert source loop nesting |
| unpack | input | 1 | Invert destination loop nesting |
| hint | input | HINT_W | Parallelism group size, zero for none |
| vf_mode | input | 1 | Vertical-first issue when high |
| step | input | 1 | Issue strobe for vertical-first mode |
| issue_valid | output | 1 | A pair is issued this cycle |
| src_step | output | VL_W | Source element index |
| src_sub | output | VL_W | Source sub-element index |
| dst_step | output | VL_W | Destination element index |
| dst_sub | output | VL_W | Destination sub-element index |
| group_end | output | 1 | Issued pair closes its parallelism group |
| done | output | 1 | Issued pair is the final one |

## Verification
The hardest case to reach is a group boundary caused by the source element index wrapping back to zero under pack, rather than by crossing a multiple of the hint. Whether the group ends there depends on whether the wrapped-from index was at least the hint. The bench reaches this case by running vertical-first mode with pack set. It uses one length larger than the hint and one length no larger than the hint, so that one configuration splits the groups at the wrap and the other merges them. It also runs a length that is not a multiple of the hint, to produce a short final group.

// File: rtl/vec_step_seq_pkg.sv
package vec_step_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HRUN  = 2'd1,
        ST_VWAIT = 2'd2,
        ST_VRUN  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/elem_loop_ctr.sv
module elem_loop_ctr #(
    parameter int VL_W  = 7,
    parameter int SUB_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            advance,
    input  logic            invert,
    input  logic [VL_W-1:0] vl_m1,
    input  logic [SUB_W-1:0] sub_m1,
    output logic [VL_W-1:0] step_idx,
    output logic [VL_W-1:0] sub_idx,
    output logic            last,
    output logic            step_inc,
    output logic            step_wrap
);
    localparam int PAD = VL_W - SUB_W;

    logic [VL_W-1:0] inner_q, outer_q;
    logic [VL_W-1:0] inner_lim, outer_lim, sub_ext;
    logic            inner_wrap;

    assign sub_ext    = {{PAD{1'b0}}, sub_m1};
    assign inner_lim  = invert ? vl_m1 : sub_ext;
    assign outer_lim  = invert ? sub_ext : vl_m1;
    assign inner_wrap = (inner_q == inner_lim);
    assign last       = inner_wrap && (outer_q == outer_lim);

    // Element index is the inner counter when inverted, else the outer one.
    assign step_idx  = invert ? inner_q : outer_q;
    assign sub_idx   = invert ? outer_q : inner_q;
    assign step_inc  = invert ? !inner_wrap : (inner_wrap && !last);
    assign step_wrap = invert ? inner_wrap : last;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            inner_q <= '0;
            outer_q <= '0;
        end else if (advance) begin
            if (inner_wrap) begin
                inner_q <= '0;
                outer_q <= (outer_q == outer_lim) ? '0 : outer_q + 1'b1;
            end else begin
                inner_q <= inner_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/par_group_track.sv
module par_group_track #(
    parameter int VL_W   = 7,
    parameter int HINT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [HINT_W-1:0] hint,
    input  logic [VL_W-1:0]   src_step,
    input  logic              step_inc,
    input  logic              step_wrap,
    input  logic              last,
    output logic              grp_end
);
    localparam int PAD = VL_W - HINT_W;

    // Tracks src_step modulo hint so no divider is needed.
    logic [HINT_W-1:0] pos_q;
    logic              no_hint, at_top, wrap_leaves;

    assign no_hint     = (hint == '0);
    assign at_top      = (pos_q == hint - 1'b1);
    assign wrap_leaves = (src_step >= {{PAD{1'b0}}, hint});
    assign grp_end     = last || no_hint
                       || (step_inc && at_top)
                       || (step_wrap && wrap_leaves);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pos_q <= '0;
        end else if (advance) begin
            if (step_wrap || no_hint) pos_q <= '0;
            else if (step_inc)        pos_q <= at_top ? '0 : pos_q + 1'b1;
        end
    end
endmodule

// File: rtl/vec_step_seq.sv
module vec_step_seq
    import vec_step_seq_pkg::*;
#(
    parameter int VL_W   = 7,
    parameter int SUB_W  = 2,
    parameter int HINT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VL_W-1:0]   vl,
    input  logic [SUB_W-1:0]  subvl_m1,
    input  logic              pack,
    input  logic              unpack,
    input  logic [HINT_W-1:0] hint,
    input  logic              vf_mode,
    input  logic              step,
    output logic              issue_valid,
    output logic [VL_W-1:0]   src_step,
    output logic [VL_W-1:0]   src_sub,
    output logic [VL_W-1:0]   dst_step,
    output logic [VL_W-1:0]   dst_sub,
    output logic              group_end,
    output logic              done
);
    seq_state_e state_q, state_d;

    logic [VL_W-1:0]   vl_q;
    logic [SUB_W-1:0]  sm1_q;
    logic [HINT_W-1:0] hint_q;
    logic              pack_q, unpack_q, vf_q;
    logic              accept, adv;
    logic              src_last, src_inc, src_wrap;
    logic              dst_last, dst_inc, dst_wrap;
    logic              grp_raw;

    assign accept = (state_q == ST_IDLE) && start && (vl != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q     <= '0;
            sm1_q    <= '0;
            hint_q   <= '0;
            pack_q   <= 1'b0;
            unpack_q <= 1'b0;
            vf_q     <= 1'b0;
        end else if (accept) begin
            vl_q     <= vl;
            sm1_q    <= subvl_m1;
            hint_q   <= hint;
            pack_q   <= pack;
            unpack_q <= unpack;
            vf_q     <= vf_mode;
        end
    end

    elem_loop_ctr #(.VL_W(VL_W), .SUB_W(SUB_W)) u_src (
        .clk(clk), .rst_n(rst_n), .clear(accept), .advance(adv),
        .invert(pack_q), .vl_m1(vl_q - 1'b1), .sub_m1(sm1_q),
        .step_idx(src_step), .sub_idx(src_sub), .last(src_last),
        .step_inc(src_inc), .step_wrap(src_wrap)
    );

    elem_loop_ctr #(.VL_W(VL_W), .SUB_W(SUB_W)) u_dst (
        .clk(clk), .rst_n(rst_n), .clear(accept), .advance(adv),
        .invert(unpack_q), .vl_m1(vl_q - 1'b1), .sub_m1(sm1_q),
        .step_idx(dst_step), .sub_idx(dst_sub), .last(dst_last),
        .step_inc(dst_inc), .step_wrap(dst_wrap)
    );

    par_group_track #(.VL_W(VL_W), .HINT_W(HINT_W)) u_grp (
        .clk(clk), .rst_n(rst_n), .clear(accept), .advance(adv),
        .hint(hint_q), .src_step(src_step), .step_inc(src_inc),
        .step_wrap(src_wrap), .last(src_last), .grp_end(grp_raw)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d     = state_q;
        issue_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = vf_mode ? ST_VWAIT : ST_HRUN;
            end
            ST_HRUN: begin
                issue_valid = 1'b1;
                if (src_last) state_d = ST_IDLE;
            end
            ST_VWAIT: begin
                if (step) state_d = ST_VRUN;
            end
            ST_VRUN: begin
                issue_valid = 1'b1;
                if (src_last)     state_d = ST_IDLE;
                else if (grp_raw) state_d = ST_VWAIT;
            end
            default: state_d = ST_IDLE;
        endcase
        adv       = issue_valid;
        done      = issue_valid && src_last;
        group_end = issue_valid && grp_raw;
    end
endmodule

// File: rtl/vec_step_seq_chk.sv
module vec_step_seq_chk #(
    parameter int VL_W   = 7,
    parameter int SUB_W  = 2,
    parameter int HINT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_valid,
    input logic              done,
    input logic              group_end,
    input logic [VL_W-1:0]   src_step,
    input logic [VL_W-1:0]   src_sub,
    input logic [VL_W-1:0]   dst_step,
    input logic [VL_W-1:0]   vl_q,
    input logic [SUB_W-1:0]  sm1_q,
    input logic [HINT_W-1:0] hint_q,
    input logic              vf_q
);
    p_done_then_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!issue_valid && src_step == '0 && src_sub == '0 && dst_step == '0));

    p_done_needs_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> issue_valid);

    p_hrun_contig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !done && !vf_q) |=> issue_valid);

    p_vf_group_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && vf_q && group_end) |=> !issue_valid);

    p_nohint_each_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && hint_q == '0) |-> group_end);

    p_index_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (src_step < vl_q && src_sub <= {{(VL_W-SUB_W){1'b0}}, sm1_q}));

    p_last_ends_group_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> group_end);
endmodule

bind vec_step_seq vec_step_seq_chk #(.VL_W(VL_W), .SUB_W(SUB_W), .HINT_W(HINT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .done(done),
    .group_end(group_end), .src_step(src_step), .src_sub(src_sub),
    .dst_step(dst_step), .vl_q(vl_q), .sm1_q(sm1_q), .hint_q(hint_q), .vf_q(vf_q)
);

// File: tb/vec_step_seq_tb.sv
module vec_step_seq_tb;
    localparam int VL_W = 7, SUB_W = 2, HINT_W = 4;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pack = 1'b0, unpack = 1'b0;
    logic vf_mode = 1'b0, step = 1'b0;
    logic [VL_W-1:0] vl = '0;
    logic [SUB_W-1:0] subvl_m1 = '0;
    logic [HINT_W-1:0] hint = '0;
    logic issue_valid, group_end, done;
    logic [VL_W-1:0] src_step, src_sub, dst_step, dst_sub;

    int checks = 0, errors = 0;
    int c_vl, c_sc, c_h;
    bit c_pk, c_up, c_vf;

    always #4 clk = ~clk;   // 125 MHz

    vec_step_seq #(.VL_W(VL_W), .SUB_W(SUB_W), .HINT_W(HINT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .subvl_m1(subvl_m1),
        .pack(pack), .unpack(unpack), .hint(hint), .vf_mode(vf_mode), .step(step),
        .issue_valid(issue_valid), .src_step(src_step), .src_sub(src_sub),
        .dst_step(dst_step), .dst_sub(dst_sub), .group_end(group_end), .done(done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference index of pair t for one side
    function automatic int ref_step(input int t, input bit inv);
        return inv ? t % c_vl : t / c_sc;
    endfunction
    function automatic int ref_sub(input int t, input bit inv);
        return inv ? t / c_vl : t % c_sc;
    endfunction
    function automatic bit ref_gend(input int t);
        int n = c_vl * c_sc;
        if (t == n - 1 || c_h == 0) return 1'b1;
        return (ref_step(t, c_pk) / c_h) != (ref_step(t + 1, c_pk) / c_h);
    endfunction

    // Runs one operation and checks every issued pair.
    task automatic run_op(input string req, input int v, input int sc, input bit pk,
                          input bit up, input int h, input bit vf);
        int n = v * sc;
        int t = 0;
        int guard = 0;
        int steps = 0;
        int exp_steps = 0;
        c_vl = v; c_sc = sc; c_pk = pk; c_up = up; c_h = h; c_vf = vf;
        for (int k = 0; k < n; k++) if (ref_gend(k)) exp_steps++;
        @(negedge clk);
        vl = VL_W'(v); subvl_m1 = SUB_W'(sc - 1); pack = pk; unpack = up;
        hint = HINT_W'(h); vf_mode = vf; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (vf) chk("R8", "valid before step", int'(issue_valid), 0);
        while (t < n && guard < 2000) begin
            guard++;
            if (!issue_valid) begin
                if (!vf) chk("R6", "gap in horizontal issue", 0, 1);
                step = 1'b1;
                steps++;
                @(negedge clk);
                step = 1'b0;
                continue;
            end
            if (!vf) step = 1'b1;   // must have no effect in horizontal mode
            chk(req, "src_step", int'(src_step), ref_step(t, pk));
            chk(req, "src_sub",  int'(src_sub),  ref_sub(t, pk));
            chk(req, "dst_step", int'(dst_step), ref_step(t, up));
            chk(req, "dst_sub",  int'(dst_sub),  ref_sub(t, up));
            chk("R9", "group_end", int'(group_end), int'(ref_gend(t)));
            chk("R7", "done", int'(done), int'(t == n - 1));
            t++;
            @(negedge clk);
            step = 1'b0;
            if (vf && t < n && ref_gend(t - 1))
                chk("R8", "issue after group end", int'(issue_valid), 0);
        end
        chk(req, "pairs issued", t, n);
        if (vf) chk("R8", "step strobes used", steps, exp_steps);
        chk("R7", "idle after done", int'(issue_valid), 0);
        chk("R7", "indices cleared", int'(src_step) + int'(src_sub) + int'(dst_step) + int'(dst_sub), 0);
    endtask

    task automatic t_reset;
        chk("R1", "issue_valid", int'(issue_valid), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "group_end", int'(group_end), 0);
        chk("R1", "indices", int'(src_step) + int'(src_sub) + int'(dst_step) + int'(dst_sub), 0);
    endtask

    task automatic t_zero_len;
        @(negedge clk);
        vl = '0; subvl_m1 = 2'd1; vf_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk("R11", "no issue on zero length", int'(issue_valid), 0);
            chk("R11", "no done on zero length", int'(done), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_op("R2", 1, 1, 0, 0, 0, 0);     // single pair
        run_op("R3", 3, 2, 0, 0, 0, 0);     // normal nesting
        run_op("R4", 3, 3, 1, 0, 0, 0);     // source inverted only
        run_op("R5", 4, 2, 0, 1, 0, 0);     // destination inverted only
        run_op("R6", 5, 4, 1, 1, 2, 0);     // horizontal ignores grouping
        run_op("R8", 6, 1, 0, 0, 2, 1);     // vertical-first, even groups
        run_op("R9", 5, 1, 0, 0, 2, 1);     // short final group
        run_op("R9", 3, 2, 0, 0, 1, 1);     // groups span sub-elements
        run_op("R9", 3, 2, 1, 0, 2, 1);     // wrap splits groups under pack
        run_op("R9", 2, 3, 1, 1, 4, 1);     // wrap merges: whole vector one group
        run_op("R10", 3, 2, 1, 0, 0, 1);    // no hint: one pair per step
        t_zero_len();
        run_op("R2", 2, 2, 0, 1, 3, 0);     // restart after zero-length start
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule